// File: doc/BRIEF.md
# Soft-Output Candidate LLR Unit

This block turns the candidate list of a list sphere detector into one soft value per coded bit for a two-antenna symbol pair. Every clock cycle a beat of up to `NCAND` candidates arrives. Each candidate carries two complex constellation points, one for each transmit antenna, and a distance metric the detector has already scaled by the noise variance. The unit takes that metric as it is and does not compute it again. A configurable Gray demapper turns each point into bits for QPSK, 16-QAM or 64-QAM. One processing element per coded bit keeps the best metric seen so far under the "bit = 1" hypothesis and under the "bit = 0" hypothesis.

A start strobe on the first beat of a list replaces all tracked maxima with that beat's values. A last strobe marks the final beat. One cycle later the unit produces a signed, clipped log-likelihood ratio for every bit and pulses the output valid signal. Optional a-priori LLRs from a decoder can be folded into the metric so the block can sit inside an iterative detection loop.

Top module: `llr_unit`

## Requirements
- R1: Per axis, a coordinate is an odd integer level a in {−(2^m−1) … 2^m−1}, where m = 1, 2 or 3 for mode 0 (QPSK), 1 (16-QAM) or 2 (64-QAM). Mode 3 behaves as 64-QAM. With level index i = (a + 2^m − 1)/2, the axis bits are the m-bit Gray code i XOR (i>>1), written most significant bit first.
- R2: With `useApriori` low, a candidate's metric is −PED. The output for bit k is floor((bestOne − bestZero)/2), where each best is the largest metric among the valid candidates of the list whose bit k is 1 (or 0).
- R3: With `useApriori` high, each candidate's metric for bit k becomes −PED + Σ_{j≠k} x_j·La_j. Here x_j = +1 when the candidate's bit j is 1 and −1 otherwise, and j runs over the active bits. The a-priori inputs have no effect while `useApriori` is low.
- R4: Bit order: within a symbol the bits are I_bit0, Q_bit0, I_bit1, Q_bit1, I_bit2, Q_bit2 (first axis bit first). Antenna 0's 2m bits take indices 0 … 2m−1 and antenna 1's take the next 2m. Output k is `llrOut[k*LLR_W +: LLR_W]`.
- R5: A beat with `beatStart` high discards all earlier tracker state. The beats of a list accumulate until the beat with `beatLast`.
- R6: `outValid` is high exactly in the cycle after a beat with `beatValid` and `beatLast`, and `llrOut` changes only at that edge.
- R7: If only the "1" hypothesis of a bit has candidates, the output is +CLIP_MAG. If only the "0" hypothesis has candidates, it is −CLIP_MAG. If neither has any, it is 0.
- R8: A computed LLR outside ±CLIP_MAG is saturated to that bound.
- R9: A candidate whose `candMask` bit is 0 has no effect on any output.
- R10: Outputs at indices 4m and above are 0.
- R11: After reset `outValid` is 0 and every LLR is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Modulation select: 0 QPSK, 1 16-QAM, 2/3 64-QAM |
| useApriori | input | 1 | Fold a-priori LLRs into the candidate metrics |
| aprioriLlr | input | 12*LA_W | Signed a-priori LLR per bit index |
| beatValid | input | 1 | Candidate beat present |
| beatStart | input | 1 | First beat of a list |
| beatLast | input | 1 | Final beat of a list |
| candMask | input | NCAND | Per-candidate valid bit |
| candSym | input | NCAND*4*SYM_W | Signed coordinates; candidate c, field q (0 ant0 I, 1 ant0 Q, 2 ant1 I, 3 ant1 Q) at (c*4+q)*SYM_W |
| candPed | input | NCAND*PED_W | Unsigned scaled distance for each candidate |
| outValid | output | 1 | One-cycle pulse with a fresh LLR vector |
| llrOut | output | 12*LLR_W | Signed clipped LLR per bit index |

## Verification
Random lists run in every mode with one to eight beats. These show that the Gray demapper, the bit ordering and the max tracking agree with a reference model that derives bits by a different arithmetic route. The same lists run with the a-priori path switched on and off, which separates the extrinsic term from plain −PED and shows that the a-priori inputs are ignored when the path is off. Random masking tells masked candidates apart from live ones. Further directed lists cover the corners: all candidates sharing one bit value, an empty list, a wide distance gap that forces saturation, and a masked candidate that would otherwise win. A stray beat between lists shows that the outputs hold and that the next start clears the trackers.

// File: rtl/llr_unit_pkg.sv
package llr_unit_pkg;

  localparam int MAX_AXIS = 3;
  localparam int NUM_ANT  = 2;

  typedef enum logic [1:0] {
    MOD_QPSK  = 2'd0,
    MOD_QAM16 = 2'd1,
    MOD_QAM64 = 2'd2,
    MOD_ALT64 = 2'd3
  } modSel_e;

  typedef struct packed {
    logic load;
    logic fresh;
    logic finish;
  } llrStrobe_t;

  function automatic logic [2:0] axisBitsPerMode(input logic [1:0] m);
    case (m)
      MOD_QPSK:  return 3'd1;
      MOD_QAM16: return 3'd2;
      default:   return 3'd3;
    endcase
  endfunction

  // index 0 is the first (most significant) Gray bit of the axis
  function automatic logic [2:0] axisGray(input logic signed [7:0] a, input logic [1:0] m);
    logic signed [7:0] mag;
    logic [2:0] r;
    mag  = (a < 0) ? -a : a;
    r[0] = (a > 0);
    r[1] = (m == MOD_QAM16) ? (mag == 8'sd1) : (mag < 8'sd4);
    r[2] = (mag == 8'sd3) || (mag == 8'sd5);
    return r;
  endfunction

endpackage

// File: rtl/llr_ctrl.sv
module llr_ctrl
  import llr_unit_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       beatValid,
  input  logic       beatStart,
  input  logic       beatLast,
  output llrStrobe_t strb,
  output logic       outValid
);

  always_comb begin
    strb.load   = beatValid;
    strb.fresh  = beatValid & beatStart;
    strb.finish = beatValid & beatLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= strb.finish;
  end

endmodule

// File: rtl/llr_datapath.sv
module llr_datapath
  import llr_unit_pkg::*;
#(
  parameter int NCAND    = 8,
  parameter int SYM_W    = 4,
  parameter int PED_W    = 12,
  parameter int LA_W     = 8,
  parameter int LLR_W    = 10,
  parameter int CLIP_MAG = 511
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  llrStrobe_t                     strb,
  input  logic [1:0]                     mode,
  input  logic                           useApriori,
  input  logic [NUM_ANT*2*MAX_AXIS*LA_W-1:0]  aprioriLlr,
  input  logic [NCAND-1:0]               candMask,
  input  logic [NCAND*4*SYM_W-1:0]       candSym,
  input  logic [NCAND*PED_W-1:0]         candPed,
  output logic [NUM_ANT*2*MAX_AXIS*LLR_W-1:0] llrOut
);

  localparam int NBITS = NUM_ANT * 2 * MAX_AXIS;
  localparam int MW    = PED_W + LA_W + 4;
  localparam logic signed [MW:0] CLIP_POS = (MW+1)'(CLIP_MAG);
  localparam logic signed [MW:0] CLIP_NEG = -CLIP_POS;

  logic [2:0]              axisCnt;
  logic [NBITS-1:0]        activeMask;
  logic [NBITS-1:0]        candBits   [NCAND];
  logic signed [MW-1:0]    laExt      [NBITS];
  logic signed [MW-1:0]    candMetric [NCAND][NBITS];
  logic signed [SYM_W-1:0] coordTmp;
  logic [2:0]              grayTmp;
  logic signed [LA_W-1:0]  laTmp;
  logic signed [MW-1:0]    pedTmp, sumTmp, selfTmp;

  // demapper and per-candidate metric
  always_comb begin
    axisCnt = axisBitsPerMode(mode);
    coordTmp = '0; grayTmp = '0; laTmp = '0;
    pedTmp = '0; sumTmp = '0; selfTmp = '0;
    for (int k = 0; k < NBITS; k++) begin
      activeMask[k] = (k < 4 * int'(axisCnt));
      laTmp    = aprioriLlr[k*LA_W +: LA_W];
      laExt[k] = MW'(laTmp);
    end
    for (int c = 0; c < NCAND; c++) begin
      candBits[c] = '0;
      for (int ant = 0; ant < NUM_ANT; ant++)
        for (int lvl = 0; lvl < MAX_AXIS; lvl++)
          for (int ax = 0; ax < 2; ax++)
            if (lvl < int'(axisCnt)) begin
              coordTmp = candSym[(c*4 + ant*2 + ax)*SYM_W +: SYM_W];
              grayTmp  = axisGray(8'(coordTmp), mode);
              candBits[c][ant*2*int'(axisCnt) + 2*lvl + ax] = grayTmp[lvl];
            end
      pedTmp = MW'({1'b0, candPed[c*PED_W +: PED_W]});
      sumTmp = '0;
      for (int j = 0; j < NBITS; j++)
        if (activeMask[j]) sumTmp = candBits[c][j] ? sumTmp + laExt[j] : sumTmp - laExt[j];
      for (int k = 0; k < NBITS; k++) begin
        selfTmp = candBits[c][k] ? laExt[k] : -laExt[k];
        candMetric[c][k] = useApriori ? (sumTmp - selfTmp - pedTmp) : -pedTmp;
      end
    end
  end

  // per-bit max trackers
  logic signed [MW-1:0] maxOne  [NBITS], maxZero  [NBITS];
  logic                 hitOne  [NBITS], hitZero  [NBITS];
  logic signed [MW-1:0] nMaxOne [NBITS], nMaxZero [NBITS];
  logic                 nHitOne [NBITS], nHitZero [NBITS];

  always_comb begin
    for (int k = 0; k < NBITS; k++) begin
      nMaxOne[k]  = strb.fresh ? '0   : maxOne[k];
      nMaxZero[k] = strb.fresh ? '0   : maxZero[k];
      nHitOne[k]  = strb.fresh ? 1'b0 : hitOne[k];
      nHitZero[k] = strb.fresh ? 1'b0 : hitZero[k];
      for (int c = 0; c < NCAND; c++) begin
        if (strb.load && candMask[c]) begin
          if (candBits[c][k]) begin
            if (!nHitOne[k] || candMetric[c][k] > nMaxOne[k]) begin
              nMaxOne[k] = candMetric[c][k];
              nHitOne[k] = 1'b1;
            end
          end else begin
            if (!nHitZero[k] || candMetric[c][k] > nMaxZero[k]) begin
              nMaxZero[k] = candMetric[c][k];
              nHitZero[k] = 1'b1;
            end
          end
        end
      end
    end
  end

  // LLR formation: halve by arithmetic shift, saturate
  logic signed [MW:0]      diffTmp [NBITS];
  logic signed [MW:0]      halfTmp [NBITS];
  logic signed [LLR_W-1:0] llrNext [NBITS];
  logic signed [LLR_W-1:0] llrReg  [NBITS];

  always_comb begin
    for (int k = 0; k < NBITS; k++) begin
      diffTmp[k] = {nMaxOne[k][MW-1], nMaxOne[k]} - {nMaxZero[k][MW-1], nMaxZero[k]};
      halfTmp[k] = diffTmp[k] >>> 1;
      if (!activeMask[k])                   llrNext[k] = '0;
      else if (nHitOne[k] && nHitZero[k]) begin
        if (halfTmp[k] > CLIP_POS)          llrNext[k] = LLR_W'(CLIP_POS);
        else if (halfTmp[k] < CLIP_NEG)     llrNext[k] = LLR_W'(CLIP_NEG);
        else                                llrNext[k] = LLR_W'(halfTmp[k]);
      end
      else if (nHitOne[k])                  llrNext[k] = LLR_W'(CLIP_POS);
      else if (nHitZero[k])                 llrNext[k] = LLR_W'(CLIP_NEG);
      else                                  llrNext[k] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NBITS; k++) begin
        maxOne[k] <= '0; maxZero[k] <= '0;
        hitOne[k] <= 1'b0; hitZero[k] <= 1'b0;
        llrReg[k] <= '0;
      end
    end else begin
      if (strb.load) begin
        for (int k = 0; k < NBITS; k++) begin
          maxOne[k] <= nMaxOne[k]; maxZero[k] <= nMaxZero[k];
          hitOne[k] <= nHitOne[k]; hitZero[k] <= nHitZero[k];
        end
      end
      if (strb.finish)
        for (int k = 0; k < NBITS; k++) llrReg[k] <= llrNext[k];
    end
  end

  for (genvar k = 0; k < NBITS; k++) begin : g_out
    assign llrOut[k*LLR_W +: LLR_W] = llrReg[k];
  end

endmodule

// File: rtl/llr_unit.sv
module llr_unit
  import llr_unit_pkg::*;
#(
  parameter int NCAND    = 8,
  parameter int SYM_W    = 4,
  parameter int PED_W    = 12,
  parameter int LA_W     = 8,
  parameter int LLR_W    = 10,
  parameter int CLIP_MAG = 511
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic [1:0]                              mode,
  input  logic                                    useApriori,
  input  logic [NUM_ANT*2*MAX_AXIS*LA_W-1:0]      aprioriLlr,
  input  logic                                    beatValid,
  input  logic                                    beatStart,
  input  logic                                    beatLast,
  input  logic [NCAND-1:0]                        candMask,
  input  logic [NCAND*4*SYM_W-1:0]                candSym,
  input  logic [NCAND*PED_W-1:0]                  candPed,
  output logic                                    outValid,
  output logic [NUM_ANT*2*MAX_AXIS*LLR_W-1:0]     llrOut
);

  llrStrobe_t strb;

  llr_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .beatValid(beatValid), .beatStart(beatStart),
    .beatLast(beatLast), .strb(strb), .outValid(outValid)
  );

  llr_datapath #(
    .NCAND(NCAND), .SYM_W(SYM_W), .PED_W(PED_W), .LA_W(LA_W),
    .LLR_W(LLR_W), .CLIP_MAG(CLIP_MAG)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .mode(mode), .useApriori(useApriori),
    .aprioriLlr(aprioriLlr), .candMask(candMask), .candSym(candSym),
    .candPed(candPed), .llrOut(llrOut)
  );

endmodule

// File: rtl/llr_unit_chk.sv
module llr_unit_chk
  import llr_unit_pkg::*;
#(
  parameter int NBITS    = 12,
  parameter int LLR_W    = 10,
  parameter int CLIP_MAG = 511
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   beatValid,
  input logic                   beatLast,
  input logic [1:0]             mode,
  input logic                   outValid,
  input logic [NBITS*LLR_W-1:0] llrOut
);

  logic [1:0] modeHeld;
  logic       overBound, inactiveBad;
  logic signed [LLR_W-1:0] v;

  always_ff @(posedge clk) begin
    if (!rstN) modeHeld <= 2'd0;
    else if (beatValid && beatLast) modeHeld <= mode;
  end

  always_comb begin
    overBound = 1'b0; inactiveBad = 1'b0; v = '0;
    for (int k = 0; k < NBITS; k++) begin
      v = llrOut[k*LLR_W +: LLR_W];
      if (int'(v) > CLIP_MAG || int'(v) < -CLIP_MAG) overBound = 1'b1;
      if (k >= 4 * int'(axisBitsPerMode(modeHeld)) && v != '0) inactiveBad = 1'b1;
    end
  end

  AST_VALID_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && beatLast) |=> outValid);                       // R6
  AST_VALID_ONLY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    !(beatValid && beatLast) |=> !outValid);                     // R6
  AST_LLR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !(beatValid && beatLast) |=> $stable(llrOut));               // R6
  AST_CLIP_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !overBound);                                    // R8
  AST_INACTIVE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inactiveBad);                                  // R10

endmodule

bind llr_unit llr_unit_chk #(
  .NBITS(llr_unit_pkg::NUM_ANT*2*llr_unit_pkg::MAX_AXIS), .LLR_W(LLR_W), .CLIP_MAG(CLIP_MAG)
) chk_i (
  .clk(clk), .rstN(rstN), .beatValid(beatValid), .beatLast(beatLast),
  .mode(mode), .outValid(outValid), .llrOut(llrOut)
);

// File: tb/llr_unit_tb_top.sv
module llr_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCAND = 8, SYM_W = 4, PED_W = 12, LA_W = 8, LLR_W = 10, CLIP_MAG = 511;
  localparam int NBITS = 12;
  localparam int MAXC  = NCAND * 8;

  // columns: mode, apriori, beats, max PED, random mask
  localparam int NVEC = 8;
  localparam int VEC [NVEC][5] = '{
    '{0, 0, 1,  600, 0}, '{1, 0, 8,  600, 0}, '{2, 0, 4,  600, 1}, '{1, 1, 8,  600, 0},
    '{2, 1, 3,  400, 1}, '{0, 1, 2,  300, 0}, '{1, 0, 2, 4095, 1}, '{3, 0, 8,  100, 0}
  };

  logic clk = 0, rstN = 0;
  logic [1:0] mode = 0;
  logic useApriori = 0;
  logic [NBITS*LA_W-1:0] aprioriLlr = '0;
  logic beatValid = 0, beatStart = 0, beatLast = 0;
  logic [NCAND-1:0] candMask = '0;
  logic [NCAND*4*SYM_W-1:0] candSym = '0;
  logic [NCAND*PED_W-1:0] candPed = '0;
  logic outValid;
  logic [NBITS*LLR_W-1:0] llrOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  llr_unit #(.NCAND(NCAND), .SYM_W(SYM_W), .PED_W(PED_W), .LA_W(LA_W),
             .LLR_W(LLR_W), .CLIP_MAG(CLIP_MAG)) dut_i (
    .clk(clk), .rstN(rstN), .mode(mode), .useApriori(useApriori), .aprioriLlr(aprioriLlr),
    .beatValid(beatValid), .beatStart(beatStart), .beatLast(beatLast), .candMask(candMask),
    .candSym(candSym), .candPed(candPed), .outValid(outValid), .llrOut(llrOut));

  int nChecks = 0, nBad = 0;
  int unsigned rs = 32'h2468_ace1;
  int curMode; bit curAp; int curLa[NBITS];
  int cSym[MAXC][4]; int cPed[MAXC]; bit cOn[MAXC]; int nCand;

  function automatic int unsigned rnd();
    rs = rs * 32'd1664525 + 32'd1013904223;
    return rs >> 8;
  endfunction

  function automatic int axisOf(int m);
    return (m == 0) ? 1 : (m == 1) ? 2 : 3;
  endfunction

  function automatic int refBit(int c, int k);
    int axis, sb, ant, p, a, i, g;
    axis = axisOf(curMode); sb = 2 * axis;
    ant = k / sb; p = k % sb;
    a = cSym[c][ant*2 + (p % 2)];
    i = (a + (1 << axis) - 1) / 2;
    g = i ^ (i >> 1);
    return (g >> (axis - 1 - p/2)) & 1;
  endfunction

  function automatic int refLlr(int k);
    int axis, met, s, bp, bm, d; bit hp, hm;
    axis = axisOf(curMode);
    if (k >= 4 * axis) return 0;
    hp = 0; hm = 0; bp = 0; bm = 0;
    for (int c = 0; c < nCand; c++) begin
      if (!cOn[c]) continue;
      met = -cPed[c];
      if (curAp) begin
        s = 0;
        for (int j = 0; j < 4 * axis; j++) if (j != k) s += (refBit(c, j) != 0 ? 1 : -1) * curLa[j];
        met += s;
      end
      if (refBit(c, k) != 0) begin if (!hp || met > bp) begin bp = met; hp = 1; end end
      else                   begin if (!hm || met > bm) begin bm = met; hm = 1; end end
    end
    if (hp && hm) begin
      d = (bp - bm) >>> 1;
      if (d > CLIP_MAG) d = CLIP_MAG;
      if (d < -CLIP_MAG) d = -CLIP_MAG;
      return d;
    end
    if (hp) return CLIP_MAG;
    if (hm) return -CLIP_MAG;
    return 0;
  endfunction

  function automatic int llrAt(int k);
    logic signed [LLR_W-1:0] t;
    t = llrOut[k*LLR_W +: LLR_W];
    return int'(t);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic genList(int m, bit ap, int beats, int pedMax, bit maskRand);
    int axis;
    curMode = m; curAp = ap; axis = axisOf(m); nCand = beats * NCAND;
    for (int j = 0; j < NBITS; j++) curLa[j] = int'(rnd() % 255) - 127;
    for (int c = 0; c < nCand; c++) begin
      for (int q = 0; q < 4; q++) cSym[c][q] = 2 * int'(rnd() % (1 << axis)) - ((1 << axis) - 1);
      cPed[c] = int'(rnd() % (pedMax + 1));
      cOn[c]  = maskRand ? (rnd() % 4 != 0) : 1'b1;
    end
  endtask

  task automatic driveList(int beats);
    for (int b = 0; b < beats; b++) begin
      @(negedge clk);
      mode = 2'(curMode); useApriori = curAp;
      for (int j = 0; j < NBITS; j++) aprioriLlr[j*LA_W +: LA_W] = LA_W'(curLa[j]);
      beatValid = 1; beatStart = (b == 0); beatLast = (b == beats - 1);
      for (int c = 0; c < NCAND; c++) begin
        candMask[c] = cOn[b*NCAND + c];
        candPed[c*PED_W +: PED_W] = PED_W'(cPed[b*NCAND + c]);
        for (int q = 0; q < 4; q++) candSym[(c*4+q)*SYM_W +: SYM_W] = SYM_W'(cSym[b*NCAND + c][q]);
      end
    end
  endtask

  // drive the list, then check valid pulse timing and every LLR
  task automatic runList(int beats, string req);
    int kBad, aBad, eBad; bit ok;
    driveList(beats);
    @(negedge clk);
    check(outValid == 1'b1, "R6 valid after last", int'(outValid), 1);
    ok = 1; kBad = 0; aBad = 0; eBad = 0;
    for (int k = 0; k < NBITS; k++)
      if (ok && llrAt(k) != refLlr(k)) begin ok = 0; kBad = k; aBad = llrAt(k); eBad = refLlr(k); end
    check(ok, $sformatf("%s bit %0d", req, kBad), aBad, eBad);
    beatValid = 0; beatStart = 0; beatLast = 0;
    @(negedge clk);
    check(outValid == 1'b0, "R6 single pulse", int'(outValid), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nBad++; nChecks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(outValid == 1'b0, "R11 valid", int'(outValid), 0);
    check(llrOut == '0, "R11 llr", int'(llrOut != '0), 0);
    rstN = 1;
    @(negedge clk);

    // table walk: R1 R2 R3 R4 R5 R9 under all modes
    for (int v = 0; v < NVEC; v++) begin
      genList(VEC[v][0], VEC[v][1] != 0, VEC[v][2], VEC[v][3], VEC[v][4] != 0);
      runList(VEC[v][2], $sformatf("R1 R2 R3 R4 R5 R9 vec %0d", v));
    end

    // R7: every candidate has bit 0 = 1 -> +CLIP on bit 0
    genList(0, 0, 1, 600, 0);
    for (int c = 0; c < nCand; c++) cSym[c][0] = 1;
    runList(1, "R7 one-sided");
    check(llrAt(0) == CLIP_MAG, "R7 bit0 clip", llrAt(0), CLIP_MAG);

    // R7: empty list -> all zero
    genList(2, 0, 1, 600, 0);
    for (int c = 0; c < nCand; c++) cOn[c] = 0;
    runList(1, "R7 empty");
    check(llrOut == '0, "R7 empty zero", int'(llrOut != '0), 0);

    // R8: wide gap saturates
    genList(1, 0, 1, 600, 0);
    for (int c = 0; c < nCand; c++) cOn[c] = (c < 2);
    for (int q = 0; q < 4; q++) begin cSym[0][q] = 3; cSym[1][q] = -3; end
    cPed[0] = 0; cPed[1] = 4000;
    runList(1, "R8 saturate");
    check(llrAt(0) == CLIP_MAG, "R8 bit0", llrAt(0), CLIP_MAG);

    // R9: masked candidate would win if counted
    genList(2, 1, 1, 600, 0);
    cOn[0] = 0; cPed[0] = 0;
    for (int c = 1; c < nCand; c++) cPed[c] = 2000 + c;
    runList(1, "R9 masked winner");

    // R10: QPSK leaves upper outputs at zero
    genList(0, 1, 2, 600, 0);
    runList(2, "R10 list");
    begin
      bit z; z = 1;
      for (int k = 4; k < NBITS; k++) if (llrAt(k) != 0) z = 0;
      check(z, "R10 upper zero", int'(!z), 0);
    end

    // R6 hold on a stray beat, then R5 fresh start clears it
    begin
      logic [NBITS*LLR_W-1:0] held;
      held = llrOut;
      genList(2, 0, 1, 50, 0);
      @(negedge clk);
      mode = 2'd2; beatValid = 1; beatStart = 1; beatLast = 0; candMask = '1;
      candPed = '0;
      @(negedge clk);
      beatValid = 0; beatStart = 0;
      check(outValid == 1'b0, "R6 no pulse without last", int'(outValid), 0);
      check(llrOut == held, "R6 llr held", int'(llrOut != held), 0);
    end
    genList(2, 0, 2, 600, 0);
    runList(2, "R5 fresh after stray");

    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule